// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a full-duplex serial port with four framing and timing modes, selected by a two-bit field in its control register. Mode 0 is a synchronous 8-bit shift register. Data moves on the RXD pin and the shift clock is driven on TXD. Modes 1 to 3 are asynchronous. Mode 1 sends a 10-bit frame. Modes 2 and 3 send an 11-bit frame that carries a programmable ninth bit, which can be used to filter addresses on a multi-drop link. Modes 0 and 2 run from the system clock at a fixed division. Modes 1 and 3 take their rate from overflow pulses delivered by an external timer.

Software writes the control register, writes a byte to start a transmission, and reads the received byte. Completion of a frame is reported through a transmit flag and a receive flag held in the control register. Software clears a flag by writing the register. The receiver oversamples each asynchronous bit 16 times and decides its value by majority.

Top module: `quad_mode_uart`

## Requirements
- R1: Control register bits: [7:6] mode (00 shift, 01 10-bit timer rate, 10 11-bit fixed rate, 11 11-bit timer rate), [5] multiprocessor filter, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit flag, [0] receive flag. A write loads all eight bits, a read returns them, and reset clears the register to 0.
- R2: After reset TXD and RXD outputs idle high, the RXD driver is off, and the received byte reads 0.
- R3: In mode 0 a write of the transmit byte drives 8 bits, LSB first, on the RXD output with its driver enabled. Each bit lasts 12 clocks. During each bit TXD is low for the first half and high for the second half.
- R4: In mode 0, a control write that leaves mode 0, receive enable 1 and receive flag 0 clocks in 8 bits from RXD, LSB first. Each bit is sampled at the end of the TXD-high half. The port then sets the receive flag and presents the byte.
- R5: In mode 1 the transmit frame is a 0 start bit, 8 data bits LSB first, and a 1 stop bit. Each bit lasts 32 timer overflows, or 16 when the doubling input is 1.
- R6: In mode 2 the frame is start, 8 data bits, the transmit ninth bit, then stop. Each bit lasts 64 clocks, or 32 with doubling.
- R7: Mode 3 uses the mode 2 frame with the mode 1 bit timing.
- R8: The transmit flag stays 0 while the frame is on the line and is set once the stop bit (or the 8th bit in mode 0) has ended.
- R9: The asynchronous receiver decides each bit by majority over samples 7, 8 and 9 of 16 per bit. A low pulse on an idle line that has gone high again by mid-bit starts no frame and sets no flag.
- R10: A received asynchronous frame stores its byte and sets the receive flag. The received ninth bit takes the ninth data bit in modes 2 and 3, and the stop bit in mode 1.
- R11: While receive enable is 0, incoming frames leave the flag and the received byte unchanged.
- R12: In modes 2 and 3 with the multiprocessor bit at 1, a frame whose ninth bit is 0 is dropped, and a frame whose ninth bit is 1 is accepted.
- R13: A frame that completes while the receive flag is still 1 is discarded, so the earlier byte stays readable.

Port table, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control register write value |
| ctrlRdata | output | 8 | Control register contents |
| txWe | input | 1 | Transmit byte write strobe, starts a frame |
| txData | input | 8 | Byte to transmit |
| rxData | output | 8 | Last accepted received byte |
| timerOvf | input | 1 | One-clock overflow pulse from the rate timer |
| rateDbl | input | 1 | Rate doubling select |
| rxdIn | input | 1 | RXD pin input |
| rxdOut | output | 1 | RXD pin output value (mode 0 transmit) |
| rxdOe | output | 1 | RXD pin output enable |
| txdOut | output | 1 | TXD pin: serial data, or shift clock in mode 0 |

## Verification
Transmit frames are run from a table that covers each asynchronous mode, both doubling settings and both ninth-bit values. This separates the 10-bit frame from the 11-bit frame, the fixed rate from the timer rate, and the ninth bit from the stop bit. The data bytes have alternating, mirrored and single-edge patterns, so that a reversed or shifted bit order shows up. On the receive side, frames are sent with ninth bits of 0 and of 1 while the filter bit is set and while it is clear, which tells address frames from data frames. A short start glitch checks that false starts are rejected. Further frames arrive while the port is disabled and while the flag is still set, and these must leave the stored byte unchanged.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    SHIFT8     = 2'd0,
    ASYNC10    = 2'd1,
    ASYNC11FIX = 2'd2,
    ASYNC11TMR = 2'd3
  } portMode_e;

  typedef struct packed {
    portMode_e  mode;
    logic       tick;
    logic       txLoad;
    logic       shiftRxStart;
    logic       rxArm;
    logic       txNinth;
    logic [7:0] txByte;
  } spStrobe_t;
endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl import sport_pkg::*; #(
  parameter int MODE0_DIV   = 12,
  parameter int MODE2_DIV   = 64,
  parameter int OVF_PER_BIT = 32,
  parameter int OVERSAMPLE  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  output logic [7:0] ctrlRdata,
  input  logic       txWe,
  input  logic [7:0] txData,
  output logic [7:0] rxData,
  input  logic       timerOvf,
  input  logic       rateDbl,
  input  logic       rxDoneV,
  input  logic [7:0] rxDoneData,
  input  logic       rxDoneNinth,
  input  logic       txDoneV,
  output spStrobe_t  strb
);
  localparam int HALF0    = MODE0_DIV / 2;
  localparam int FIX_TICK = MODE2_DIV / OVERSAMPLE;
  localparam int OVF_TICK = OVF_PER_BIT / OVERSAMPLE;
  localparam int CW       = $clog2(HALF0 + FIX_TICK + OVF_TICK + 1) + 1;

  logic [1:0]    modeQ;
  logic          mpQ, rxEnQ, txNinthQ, rxNinthQ, txFlagQ, rxFlagQ;
  logic [7:0]    rxBufQ;
  logic [CW-1:0] divCnt, divNeed;
  logic          tickQ;

  wire timerRate = modeQ[0];
  wire countEv   = timerRate ? timerOvf : 1'b1;

  always_comb begin
    if (modeQ == 2'b00)  divNeed = CW'(HALF0);
    else if (timerRate)  divNeed = rateDbl ? CW'(OVF_TICK / 2) : CW'(OVF_TICK);
    else                 divNeed = rateDbl ? CW'(FIX_TICK / 2) : CW'(FIX_TICK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      tickQ  <= 1'b0;
    end else begin
      tickQ <= 1'b0;
      if (countEv) begin
        if (divCnt + CW'(1) >= divNeed) begin
          divCnt <= '0;
          tickQ  <= 1'b1;
        end else begin
          divCnt <= divCnt + CW'(1);
        end
      end
    end
  end

  wire mpBlock  = modeQ[1] && mpQ && !rxDoneNinth;
  wire rxAccept = rxDoneV && !rxFlagQ && !mpBlock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {modeQ, mpQ, rxEnQ, txNinthQ, rxNinthQ, txFlagQ, rxFlagQ} <= 8'h00;
      rxBufQ <= 8'h00;
    end else begin
      if (ctrlWe) {modeQ, mpQ, rxEnQ, txNinthQ, rxNinthQ, txFlagQ, rxFlagQ} <= ctrlWdata;
      if (txDoneV) txFlagQ <= 1'b1;
      if (rxAccept) begin
        rxFlagQ <= 1'b1;
        rxBufQ  <= rxDoneData;
        if (modeQ != 2'b00) rxNinthQ <= rxDoneNinth;
      end
    end
  end

  assign ctrlRdata = {modeQ, mpQ, rxEnQ, txNinthQ, rxNinthQ, txFlagQ, rxFlagQ};
  assign rxData    = rxBufQ;

  assign strb.mode         = portMode_e'(modeQ);
  assign strb.tick         = tickQ;
  assign strb.txLoad       = txWe;
  assign strb.txByte       = txData;
  assign strb.txNinth      = txNinthQ;
  assign strb.rxArm        = rxEnQ && (modeQ != 2'b00);
  assign strb.shiftRxStart = ctrlWe && (ctrlWdata[7:6] == 2'b00) && ctrlWdata[4] && !ctrlWdata[0];

  assert_tick_from_ovf_R5: assert property (@(posedge clk) disable iff (!rstN)
    tickQ && $past(timerRate) |-> $past(timerOvf));
  assert_rxflag_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlagQ) |-> $past(rxDoneV) || $past(ctrlWe));
  assert_mp_filter_R12: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneV && modeQ[1] && mpQ && !rxDoneNinth && !rxFlagQ && !ctrlWe |=> !rxFlagQ);
  assert_overrun_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneV && rxFlagQ && !ctrlWe |=> $stable(rxBufQ));
endmodule

// File: rtl/sport_dp.sv
module sport_dp import sport_pkg::*; #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  spStrobe_t  strb,
  input  logic       rxdIn,
  output logic       rxdOut,
  output logic       rxdOe,
  output logic       txdOut,
  output logic       txDoneV,
  output logic       rxDoneV,
  output logic [7:0] rxDoneData,
  output logic       rxDoneNinth
);
  localparam int SW  = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2;

  logic rxdMeta, rxdSync;
  always_ff @(posedge clk) begin
    if (!rstN) {rxdMeta, rxdSync} <= 2'b11;
    else       {rxdMeta, rxdSync} <= {rxdIn, rxdMeta};
  end

  // transmit engine, also the mode 0 receive shifter
  logic          txPend, txBusy, shRecv, shRxDoneQ;
  logic [10:0]   txShift, frameTx;
  logic [3:0]    bitsLeft, bitsTx;
  logic [SW-1:0] txSub;
  logic [7:0]    shRxDataQ;

  wire shiftMode = (strb.mode == SHIFT8);
  wire [SW-1:0] subLast = shiftMode ? SW'(1) : SW'(OVERSAMPLE - 1);

  always_comb begin
    frameTx = {3'b111, strb.txByte};
    bitsTx  = 4'd8;
    if (strb.mode == ASYNC10) begin
      frameTx = {2'b11, strb.txByte, 1'b0};
      bitsTx  = 4'd10;
    end else if (!shiftMode) begin
      frameTx = {1'b1, strb.txNinth, strb.txByte, 1'b0};
      bitsTx  = 4'd11;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPend <= 1'b0; txBusy <= 1'b0; shRecv <= 1'b0;
      txShift <= '1; bitsLeft <= '0; txSub <= '0;
      txDoneV <= 1'b0; shRxDoneQ <= 1'b0; shRxDataQ <= '0;
    end else begin
      txDoneV   <= 1'b0;
      shRxDoneQ <= 1'b0;
      if (!txBusy && !txPend) begin
        if (strb.txLoad) begin
          txPend <= 1'b1; txShift <= frameTx; bitsLeft <= bitsTx; shRecv <= 1'b0;
        end else if (strb.shiftRxStart) begin
          txPend <= 1'b1; txShift <= '1; bitsLeft <= 4'd8; shRecv <= 1'b1;
        end
      end
      if (strb.tick) begin
        if (txPend) begin
          txPend <= 1'b0; txBusy <= 1'b1; txSub <= '0;
        end else if (txBusy) begin
          if (txSub == subLast) begin
            txSub    <= '0;
            bitsLeft <= bitsLeft - 4'd1;
            if (shiftMode) txShift[7:0] <= {shRecv ? rxdSync : 1'b1, txShift[7:1]};
            else           txShift      <= {1'b1, txShift[10:1]};
            if (bitsLeft == 4'd1) begin
              txBusy <= 1'b0;
              if (shRecv) begin
                shRxDoneQ <= 1'b1;
                shRxDataQ <= {rxdSync, txShift[7:1]};
              end else begin
                txDoneV <= 1'b1;
              end
            end
          end else begin
            txSub <= txSub + SW'(1);
          end
        end
      end
    end
  end

  assign rxdOe  = shiftMode && txBusy && !shRecv;
  assign rxdOut = rxdOe ? txShift[0] : 1'b1;
  assign txdOut = !txBusy ? 1'b1 : (shiftMode ? (txSub != '0) : txShift[0]);

  // asynchronous receiver
  logic          rxAct, prevLine, s7, s8, asDoneQ, asNinthQ;
  logic [SW-1:0] rxSub;
  logic [3:0]    rxBit;
  logic [8:0]    rxSh;
  logic [7:0]    asDataQ;

  wire       maj     = (s7 & s8) | (s7 & rxdSync) | (s8 & rxdSync);
  wire       tenBit  = (strb.mode == ASYNC10);
  wire [3:0] lastBit = tenBit ? 4'd9 : 4'd10;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxAct <= 1'b0; prevLine <= 1'b1; s7 <= 1'b1; s8 <= 1'b1;
      rxSub <= '0; rxBit <= '0; rxSh <= '0;
      asDoneQ <= 1'b0; asNinthQ <= 1'b0; asDataQ <= '0;
    end else begin
      asDoneQ <= 1'b0;
      if (!strb.rxArm) begin
        rxAct <= 1'b0;
      end else if (strb.tick) begin
        prevLine <= rxdSync;
        if (!rxAct) begin
          if (prevLine && !rxdSync) begin
            rxAct <= 1'b1; rxSub <= '0; rxBit <= '0;
          end
        end else begin
          if (rxSub == SW'(MID - 1)) s7 <= rxdSync;
          if (rxSub == SW'(MID))     s8 <= rxdSync;
          if (rxSub == SW'(MID + 1)) begin
            if (rxBit == 4'd0 && maj) begin
              rxAct <= 1'b0;
            end else if (rxBit == lastBit) begin
              rxAct    <= 1'b0;
              asDoneQ  <= 1'b1;
              asDataQ  <= tenBit ? rxSh[8:1] : rxSh[7:0];
              asNinthQ <= tenBit ? maj : rxSh[8];
            end else if (rxBit != 4'd0) begin
              rxSh <= {maj, rxSh[8:1]};
            end
          end
          if (rxSub == SW'(OVERSAMPLE - 1)) begin
            rxSub <= '0;
            rxBit <= rxBit + 4'd1;
          end else begin
            rxSub <= rxSub + SW'(1);
          end
        end
      end
    end
  end

  assign rxDoneV     = shRxDoneQ | asDoneQ;
  assign rxDoneData  = shRxDoneQ ? shRxDataQ : asDataQ;
  assign rxDoneNinth = asNinthQ;

  assert_drive_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxdOe) |-> $past(strb.tick));
  assert_txd_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    txBusy && !strb.tick && !strb.txLoad |=> $stable(txdOut) || !$stable(strb.mode));
  assert_no_rx_when_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxArm |=> !asDoneQ);
endmodule

// File: rtl/quad_mode_uart.sv
module quad_mode_uart import sport_pkg::*; #(
  parameter int MODE0_DIV   = 12,
  parameter int MODE2_DIV   = 64,
  parameter int OVF_PER_BIT = 32,
  parameter int OVERSAMPLE  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  output logic [7:0] ctrlRdata,
  input  logic       txWe,
  input  logic [7:0] txData,
  output logic [7:0] rxData,
  input  logic       timerOvf,
  input  logic       rateDbl,
  input  logic       rxdIn,
  output logic       rxdOut,
  output logic       rxdOe,
  output logic       txdOut
);
  spStrobe_t  strb;
  logic       txDoneV, rxDoneV, rxDoneNinth;
  logic [7:0] rxDoneData;

  sport_ctrl #(.MODE0_DIV(MODE0_DIV), .MODE2_DIV(MODE2_DIV),
               .OVF_PER_BIT(OVF_PER_BIT), .OVERSAMPLE(OVERSAMPLE)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .txWe(txWe), .txData(txData), .rxData(rxData), .timerOvf(timerOvf), .rateDbl(rateDbl),
    .rxDoneV(rxDoneV), .rxDoneData(rxDoneData), .rxDoneNinth(rxDoneNinth),
    .txDoneV(txDoneV), .strb(strb));

  sport_dp #(.OVERSAMPLE(OVERSAMPLE)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxdIn(rxdIn), .rxdOut(rxdOut), .rxdOe(rxdOe),
    .txdOut(txdOut), .txDoneV(txDoneV), .rxDoneV(rxDoneV), .rxDoneData(rxDoneData),
    .rxDoneNinth(rxDoneNinth));
endmodule

// File: tb/tb_quad_mode_uart.sv
module tb_quad_mode_uart;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       ctrlWe = 1'b0, txWe = 1'b0, timerOvf = 1'b0, rateDbl = 1'b0, rxdIn = 1'b1;
  logic [7:0] ctrlWdata = '0, txData = '0;
  logic [7:0] ctrlRdata, rxData;
  logic       rxdOut, rxdOe, txdOut;
  int checks = 0, errors = 0, cyc = 0, ovfCnt = 0;
  bit finished = 0;

  quad_mode_uart dut (.clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .txWe(txWe), .txData(txData), .rxData(rxData),
    .timerOvf(timerOvf), .rateDbl(rateDbl), .rxdIn(rxdIn), .rxdOut(rxdOut),
    .rxdOe(rxdOe), .txdOut(txdOut));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  // timer overflow every 3 clocks
  always @(negedge clk) begin
    ovfCnt   <= (ovfCnt == 2) ? 0 : ovfCnt + 1;
    timerOvf <= (ovfCnt == 2);
  end

  // {mode[1:0], dbl, ninth, data[7:0]}
  localparam logic [11:0] TXV [5] = '{
    {2'd1, 1'b0, 1'b0, 8'hA5}, {2'd1, 1'b1, 1'b0, 8'h3C}, {2'd2, 1'b0, 1'b1, 8'h81},
    {2'd2, 1'b1, 1'b0, 8'h7E}, {2'd3, 1'b0, 1'b1, 8'h5A}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic writeTx(input logic [7:0] v);
    @(negedge clk); txWe = 1'b1; txData = v;
    @(negedge clk); txWe = 1'b0;
  endtask

  task automatic waitTxd(input logic want);
    for (int n = 0; n < 5000 && txdOut !== want; n++) @(negedge clk);
  endtask

  function automatic int bitClocks(input logic [1:0] m, input logic d);
    if (m[0]) return d ? 48 : 96;
    return d ? 32 : 64;
  endfunction

  task automatic sendFrame(input int bc, input int nb, input logic [10:0] fr);
    for (int i = 0; i < nb; i++) begin
      rxdIn = fr[i];
      repeat (bc) @(negedge clk);
    end
    rxdIn = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [10:0] got, expF;
    int bc, nb, t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 R2 reset state
    check(ctrlRdata == 8'h00, "R1 reset ctrl", ctrlRdata, 0);
    check(txdOut && rxdOut && !rxdOe, "R2 idle pins", {txdOut, rxdOut, rxdOe}, 3'b110);
    check(rxData == 8'h00, "R2 rx byte", rxData, 0);
    writeCtrl(8'hAC);
    check(ctrlRdata == 8'hAC, "R1 readback", ctrlRdata, 8'hAC);
    writeCtrl(8'h00);

    // table of asynchronous transmit frames (R5 R6 R7 R8)
    foreach (TXV[k]) begin
      rateDbl = TXV[k][9];
      writeCtrl({TXV[k][11:10], 2'b00, TXV[k][8], 3'b000});
      writeTx(TXV[k][7:0]);
      bc = bitClocks(TXV[k][11:10], TXV[k][9]);
      nb = (TXV[k][11:10] == 2'd1) ? 10 : 11;
      expF = (nb == 10) ? {2'b11, TXV[k][7:0], 1'b0} : {1'b1, TXV[k][8], TXV[k][7:0], 1'b0};
      got = '1;
      waitTxd(1'b0);
      repeat (bc / 2) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
        got[i] = txdOut;
        if (i == nb - 1) check(ctrlRdata[1] == 1'b0, "R8 flag during stop", ctrlRdata[1], 0);
        if (i < nb - 1) repeat (bc) @(negedge clk);
      end
      check(got == expF, "R5 R6 R7 frame", got, expF);
      repeat (bc / 2 + 6) @(negedge clk);
      check(ctrlRdata[1] == 1'b1, "R8 flag after frame", ctrlRdata[1], 1);
    end
    rateDbl = 1'b0;

    // R3 mode 0 transmit
    writeCtrl(8'h00);
    writeTx(8'hC6);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      waitTxd(1'b0);
      waitTxd(1'b1);
      if (i == 0) t0 = cyc;
      if (i == 1) check(cyc - t0 == 12, "R3 bit period", cyc - t0, 12);
      if (i == 0) check(rxdOe == 1'b1, "R3 driver on", rxdOe, 1);
      got[i] = rxdOut;
    end
    check(got[7:0] == 8'hC6, "R3 shift out", got[7:0], 8'hC6);
    repeat (12) @(negedge clk);
    check(ctrlRdata[1] && !rxdOe, "R8 R3 done", {ctrlRdata[1], rxdOe}, 2'b10);

    // R4 mode 0 receive
    writeCtrl(8'h10);
    for (int i = 0; i < 8; i++) begin
      waitTxd(1'b0);
      rxdIn = 8'h9B >> i;
      waitTxd(1'b1);
    end
    repeat (20) @(negedge clk);
    rxdIn = 1'b1;
    check(ctrlRdata[0] && rxData == 8'h9B, "R4 shift in", rxData, 8'h9B);
    writeCtrl(8'h00);

    // R10 mode 1 receive, stop bit into ninth
    writeCtrl(8'h50);
    repeat (20) @(negedge clk);
    sendFrame(96, 10, {2'b11, 8'hD2, 1'b0});
    check(ctrlRdata[0] && rxData == 8'hD2, "R10 mode1 byte", rxData, 8'hD2);
    check(ctrlRdata[2] == 1'b1, "R10 stop in ninth", ctrlRdata[2], 1);
    // R13 overrun
    sendFrame(96, 10, {2'b11, 8'h33, 1'b0});
    check(rxData == 8'hD2 && ctrlRdata[0], "R13 overrun keeps", rxData, 8'hD2);
    // R11 disabled
    writeCtrl(8'h40);
    sendFrame(96, 10, {2'b11, 8'h44, 1'b0});
    check(!ctrlRdata[0] && rxData == 8'hD2, "R11 disabled", {ctrlRdata[0], rxData}, 9'h0D2);
    // R9 false start then valid frame
    writeCtrl(8'h50);
    rxdIn = 1'b0; repeat (20) @(negedge clk); rxdIn = 1'b1;
    repeat (1200) @(negedge clk);
    check(!ctrlRdata[0], "R9 glitch ignored", ctrlRdata[0], 0);
    sendFrame(96, 10, {2'b11, 8'h6E, 1'b0});
    check(ctrlRdata[0] && rxData == 8'h6E, "R9 resync", rxData, 8'h6E);

    // R12 multiprocessor filter in mode 2
    writeCtrl(8'hB0);
    sendFrame(64, 11, {1'b1, 1'b0, 8'h11, 1'b0});
    check(!ctrlRdata[0] && rxData == 8'h6E, "R12 drop ninth 0", rxData, 8'h6E);
    sendFrame(64, 11, {1'b1, 1'b1, 8'h22, 1'b0});
    check(ctrlRdata[0] && rxData == 8'h22 && ctrlRdata[2], "R12 accept ninth 1", rxData, 8'h22);

    // R10 R7 mode 3 receive with ninth 0 and no filter
    writeCtrl(8'hD0);
    sendFrame(96, 11, {1'b1, 1'b0, 8'h9C, 1'b0});
    check(ctrlRdata[0] && rxData == 8'h9C && !ctrlRdata[2], "R10 mode3 ninth", ctrlRdata, 8'hD1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule